// File: doc/BRIEF.md
# Exception Entry Sequencer

This block moves a processor from normal execution into an exception handler. Once the core raises an exception request, the sequencer takes a private snapshot of the status register. It then raises the privilege level and stops tracing. For an interrupt it reads the vector number from the interrupting device through an acknowledge cycle. Except after a reset, it saves the return context on the supervisor stack. Finally it reads the handler address from a vector table that software can relocate, and hands that address back as the new program counter.

Each exception request is a valid/ready transfer. The block holds `req_ready` high only while it is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high, and `req_valid` has no effect at any other time. Memory traffic uses one word-wide master port. The block raises `bus_valid` together with the address, function code, direction and write data, and holds all of them unchanged until the responder returns `bus_ack`. The responder can stall each access for any number of cycles by keeping `bus_ack` low. When the new program counter is ready, `done` pulses for one cycle.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, or once a sequence finishes, `req_ready` is high. It goes low in the cycle after a request is taken and stays low until `done`. A `req_valid` raised while `req_ready` is low has no effect on the bus traffic, on `sr_out`, on `ssp_out` or on `pc_out`.
- R2: In the cycle after a request is taken, `sr_out` equals `sr_in` with bit 13 (supervisor) set and bits 15 and 14 (trace) cleared. The mask field, bits 10:8, becomes the request level for an interrupt (cause 1) and 7 for a reset (cause 0). For any other cause the mask field is copied unchanged.
- R3: For an interrupt, the first bus access is a read with function code 7. Its address has every bit set except bits 3:1, which carry the request level. Bits 7:0 of the returned word become the vector number.
- R4: For any cause other than reset, three word writes with function code 5 come next. The supervisor stack pointer is decremented by 2 before each write. The writes carry PC bits 15:0, then PC bits 31:16, then the status register as it was before the update. `ssp_out` ends at `ssp_in` minus 6.
- R5: For a reset (cause 0), there is no acknowledge cycle and no push. The vector base is taken as zero, and the vector reads use function code 6. `ssp_out` equals `ssp_in`.
- R6: The vector address is base plus four times the 8-bit vector number. The handler address is read as two words: the high word at the vector address, then the low word at that address plus 2. For every cause except reset both reads use function code 5.
- R7: The cycle after the final read is acknowledged, `pc_out` holds the high word joined to the low word and `done` is high. `done` is high for exactly one cycle.
- R8: While `bus_valid` is high and `bus_ack` is low, the bus address, function code, direction and write data stay stable. Each access completes on exactly one acknowledged edge.
- R9: Reset gives `sr_out` = 0x2700, `pc_out` = 0, `ssp_out` = 0, `done` = 0, `bus_valid` = 0 and `req_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exception request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_cause | input | 2 | 0 reset, 1 interrupt, 2 or 3 other cause |
| req_vector | input | 8 | Internally supplied vector number |
| req_level | input | 3 | Pending interrupt level |
| sr_in | input | 16 | Current status register |
| pc_in | input | 32 | Program counter to save |
| ssp_in | input | 32 | Current supervisor stack pointer |
| vbr_in | input | 32 | Vector table base |
| bus_valid | output | 1 | Bus access requested |
| bus_ack | input | 1 | Access completes on this edge |
| bus_addr | output | 32 | Byte address |
| bus_fc | output | 3 | Function code (address space) |
| bus_write | output | 1 | 1 write, 0 read |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid with bus_ack |
| sr_out | output | 16 | Updated status register |
| ssp_out | output | 32 | Updated supervisor stack pointer |
| pc_out | output | 32 | Handler program counter |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong sequencer state shows up at the bus port within one access. The symptom is a missing or extra transfer, a write where a read belongs, or the wrong function code. A slip in the saved status copy or the stack pointer shows up as the wrong data or address on a push write, and the stack pointer error also remains in `ssp_out` once `done` is seen. A fault in the vector arithmetic produces a wrong read address, and the responder then returns a different word, so `pc_out` is already wrong in the cycle that `done` is high.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [1:0] {
    CAUSE_RESET = 2'd0,
    CAUSE_IRQ   = 2'd1,
    CAUSE_OTHER = 2'd2,
    CAUSE_MISC  = 2'd3
  } cause_t;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_IACK     = 3'd1,
    ST_PUSH_PCL = 3'd2,
    ST_PUSH_PCH = 3'd3,
    ST_PUSH_SR  = 3'd4,
    ST_VEC_HI   = 3'd5,
    ST_VEC_LO   = 3'd6
  } seq_state_t;

  localparam int SR_T1     = 15;
  localparam int SR_T0     = 14;
  localparam int SR_SUP    = 13;
  localparam int SR_IPM_LO = 8;

  localparam logic [2:0] FC_SDATA = 3'd5;
  localparam logic [2:0] FC_SPROG = 3'd6;
  localparam logic [2:0] FC_CPU   = 3'd7;
endpackage

// File: rtl/exc_sr_next.sv
module exc_sr_next
  import exc_pkg::*;
#(
  parameter int SRW = 16,
  parameter int LW  = 3
) (
  input  logic [SRW-1:0] sr_cur,
  input  cause_t         cause,
  input  logic [LW-1:0]  level,
  output logic [SRW-1:0] sr_new
);
  always_comb begin
    sr_new         = sr_cur;
    sr_new[SR_T1]  = 1'b0;
    sr_new[SR_T0]  = 1'b0;
    sr_new[SR_SUP] = 1'b1;
    if (cause == CAUSE_RESET)
      sr_new[SR_IPM_LO +: LW] = {LW{1'b1}};
    else if (cause == CAUSE_IRQ)
      sr_new[SR_IPM_LO +: LW] = level;
  end
endmodule

// File: rtl/exc_vec_addr.sv
module exc_vec_addr
  import exc_pkg::*;
#(
  parameter int AW = 32,
  parameter int VW = 8
) (
  input  logic [AW-1:0] base,
  input  logic [VW-1:0] vec,
  input  logic          low_half,
  input  logic          is_reset,
  output logic [AW-1:0] addr,
  output logic [2:0]    fc
);
  localparam int SCALE_SH = 2;
  localparam logic [AW-1:0] HALF_OFS = AW'(2);

  logic [AW-1:0] scaled;

  generate
    if (AW > VW + SCALE_SH) begin : g_wide
      assign scaled = {{(AW-VW-SCALE_SH){1'b0}}, vec, {SCALE_SH{1'b0}}};
    end else begin : g_narrow
      assign scaled = AW'({vec, {SCALE_SH{1'b0}}});
    end
  endgenerate

  assign addr = base + scaled + (low_half ? HALF_OFS : '0);
  assign fc   = is_reset ? FC_SPROG : FC_SDATA;
endmodule

// File: rtl/exc_bus_mux.sv
module exc_bus_mux
  import exc_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 16,
  parameter int LW  = 3,
  parameter int SRW = 16
) (
  input  seq_state_t       st,
  input  logic [AW-1:0]    ssp,
  input  logic [2*DW-1:0]  pc_sav,
  input  logic [SRW-1:0]   sr_copy,
  input  logic [LW-1:0]    lvl,
  input  logic [AW-1:0]    vaddr,
  input  logic [2:0]       vfc,
  output logic             bus_valid,
  output logic [AW-1:0]    bus_addr,
  output logic [2:0]       bus_fc,
  output logic             bus_write,
  output logic [DW-1:0]    bus_wdata
);
  localparam logic [AW-1:0] WORD_BYTES = AW'(2);

  logic [AW-1:0] iack_addr;
  logic [AW-1:0] push_addr;

  assign iack_addr = {{(AW-LW-1){1'b1}}, lvl, 1'b1};
  assign push_addr = ssp - WORD_BYTES;

  always_comb begin
    bus_valid = 1'b0;
    bus_addr  = '0;
    bus_fc    = FC_SDATA;
    bus_write = 1'b0;
    bus_wdata = '0;
    unique case (st)
      ST_IACK: begin
        bus_valid = 1'b1;
        bus_addr  = iack_addr;
        bus_fc    = FC_CPU;
      end
      ST_PUSH_PCL: begin
        bus_valid = 1'b1;
        bus_addr  = push_addr;
        bus_write = 1'b1;
        bus_wdata = pc_sav[DW-1:0];
      end
      ST_PUSH_PCH: begin
        bus_valid = 1'b1;
        bus_addr  = push_addr;
        bus_write = 1'b1;
        bus_wdata = pc_sav[2*DW-1:DW];
      end
      ST_PUSH_SR: begin
        bus_valid = 1'b1;
        bus_addr  = push_addr;
        bus_write = 1'b1;
        bus_wdata = DW'(sr_copy);
      end
      ST_VEC_HI, ST_VEC_LO: begin
        bus_valid = 1'b1;
        bus_addr  = vaddr;
        bus_fc    = vfc;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 16,
  parameter int VW  = 8,
  parameter int LW  = 3,
  parameter int SRW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_cause,
  input  logic [VW-1:0]    req_vector,
  input  logic [LW-1:0]    req_level,
  input  logic [SRW-1:0]   sr_in,
  input  logic [2*DW-1:0]  pc_in,
  input  logic [AW-1:0]    ssp_in,
  input  logic [AW-1:0]    vbr_in,
  output logic             bus_valid,
  input  logic             bus_ack,
  output logic [AW-1:0]    bus_addr,
  output logic [2:0]       bus_fc,
  output logic             bus_write,
  output logic [DW-1:0]    bus_wdata,
  input  logic [DW-1:0]    bus_rdata,
  output logic [SRW-1:0]   sr_out,
  output logic [AW-1:0]    ssp_out,
  output logic [2*DW-1:0]  pc_out,
  output logic             done
);
  localparam int PCW = 2 * DW;
  localparam logic [SRW-1:0] SR_RST =
    SRW'((1 << SR_SUP) | (((1 << LW) - 1) << SR_IPM_LO));
  localparam logic [AW-1:0] WORD_BYTES = AW'(2);

  seq_state_t     st;
  cause_t         cause_in;
  cause_t         cause_q;
  logic [SRW-1:0] sr_copy;
  logic [SRW-1:0] sr_new;
  logic [PCW-1:0] pc_sav;
  logic [AW-1:0]  base_q;
  logic [VW-1:0]  vec_q;
  logic [LW-1:0]  lvl_q;
  logic [DW-1:0]  vhi_q;
  logic [AW-1:0]  vaddr;
  logic [2:0]     vfc;
  logic           accept;
  logic           adv;

  assign cause_in  = cause_t'(req_cause);
  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign adv       = bus_valid && bus_ack;

  exc_sr_next #(.SRW(SRW), .LW(LW)) u_srn (
    .sr_cur (sr_in),
    .cause  (cause_in),
    .level  (req_level),
    .sr_new (sr_new)
  );

  exc_vec_addr #(.AW(AW), .VW(VW)) u_va (
    .base     (base_q),
    .vec      (vec_q),
    .low_half (st == ST_VEC_LO),
    .is_reset (cause_q == CAUSE_RESET),
    .addr     (vaddr),
    .fc       (vfc)
  );

  exc_bus_mux #(.AW(AW), .DW(DW), .LW(LW), .SRW(SRW)) u_mux (
    .st        (st),
    .ssp       (ssp_out),
    .pc_sav    (pc_sav),
    .sr_copy   (sr_copy),
    .lvl       (lvl_q),
    .vaddr     (vaddr),
    .vfc       (vfc),
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .bus_fc    (bus_fc),
    .bus_write (bus_write),
    .bus_wdata (bus_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cause_q <= CAUSE_OTHER;
      sr_out  <= SR_RST;
      sr_copy <= '0;
      pc_sav  <= '0;
      pc_out  <= '0;
      ssp_out <= '0;
      base_q  <= '0;
      vec_q   <= '0;
      lvl_q   <= '0;
      vhi_q   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            sr_copy <= sr_in;
            sr_out  <= sr_new;
            pc_sav  <= pc_in;
            ssp_out <= ssp_in;
            base_q  <= (cause_in == CAUSE_RESET) ? '0 : vbr_in;
            vec_q   <= req_vector;
            lvl_q   <= req_level;
            cause_q <= cause_in;
            if (cause_in == CAUSE_RESET)    st <= ST_VEC_HI;
            else if (cause_in == CAUSE_IRQ) st <= ST_IACK;
            else                            st <= ST_PUSH_PCL;
          end
        end
        ST_IACK: if (adv) begin
          vec_q <= bus_rdata[VW-1:0];
          st    <= ST_PUSH_PCL;
        end
        ST_PUSH_PCL: if (adv) begin
          ssp_out <= ssp_out - WORD_BYTES;
          st      <= ST_PUSH_PCH;
        end
        ST_PUSH_PCH: if (adv) begin
          ssp_out <= ssp_out - WORD_BYTES;
          st      <= ST_PUSH_SR;
        end
        ST_PUSH_SR: if (adv) begin
          ssp_out <= ssp_out - WORD_BYTES;
          st      <= ST_VEC_HI;
        end
        ST_VEC_HI: if (adv) begin
          vhi_q <= bus_rdata;
          st    <= ST_VEC_LO;
        end
        ST_VEC_LO: if (adv) begin
          pc_out <= {vhi_q, bus_rdata};
          done   <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R8
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ack |=> bus_valid && $stable(bus_addr) && $stable(bus_fc)
      && $stable(bus_write) && $stable(bus_wdata));

  // R1
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(sr_out));

  // R2
  sup_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> sr_out[SR_SUP] && !sr_out[SR_T1] && !sr_out[SR_T0] && !req_ready);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && bus_ack |=> ssp_out == $past(ssp_out) - WORD_BYTES);

  // R4
  push_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write |-> bus_fc == FC_SDATA);

  // R5
  reset_nopush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && cause_q == CAUSE_RESET |-> !bus_write && bus_fc == FC_SPROG);
endmodule

// File: tb/sim_exc_entry_seq.sv
`timescale 1ns/1ps
module sim_exc_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_cause = '0;
  logic [7:0]  req_vector = '0;
  logic [2:0]  req_level = '0;
  logic [15:0] sr_in = '0;
  logic [31:0] pc_in = '0;
  logic [31:0] ssp_in = '0;
  logic [31:0] vbr_in = '0;
  logic        bus_valid;
  logic        bus_ack = 1'b0;
  logic [31:0] bus_addr;
  logic [2:0]  bus_fc;
  logic        bus_write;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = '0;
  logic [15:0] sr_out;
  logic [31:0] ssp_out;
  logic [31:0] pc_out;
  logic        done;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  exc_entry_seq u0 (.*);

  logic [7:0]  iack_vec = '0;
  int          log_n = 0;
  logic [31:0] log_addr [8];
  logic [2:0]  log_fc   [8];
  logic        log_wr   [8];
  logic [15:0] log_wd   [8];
  int          wcnt = 0;
  logic        prev_wait = 1'b0;
  logic [31:0] prev_addr = '0;
  logic [15:0] prev_wd = '0;
  int          hold_bad = 0;

  function automatic logic [15:0] mem_word(logic [31:0] a);
    return a[31:16] ^ a[15:0] ^ 16'h5A3C;
  endfunction

  function automatic logic [31:0] iack_addr(logic [2:0] l);
    return {28'hFFFFFFF, l, 1'b1};
  endfunction

  function automatic logic [15:0] exp_sr(logic [1:0] c, logic [15:0] s, logic [2:0] l);
    logic [15:0] r;
    r = (s & 16'h3FFF) | 16'h2000;
    if (c == 2'd0) r[10:8] = 3'd7;
    else if (c == 2'd1) r[10:8] = l;
    return r;
  endfunction

  // bus responder with random stall
  always @(posedge clk) begin
    if (bus_valid && !bus_ack && prev_wait &&
        (bus_addr !== prev_addr || bus_wdata !== prev_wd)) hold_bad <= hold_bad + 1;
    prev_wait <= bus_valid && !bus_ack;
    prev_addr <= bus_addr;
    prev_wd   <= bus_wdata;
    if (bus_ack) begin
      bus_ack <= 1'b0;
      wcnt    <= int'($urandom % 3);
    end else if (bus_valid) begin
      if (wcnt == 0) begin
        bus_ack <= 1'b1;
        if (bus_fc == 3'd7) bus_rdata <= {8'h00, iack_vec};
        else bus_rdata <= mem_word(bus_addr);
        if (log_n < 8) begin
          log_addr[log_n] <= bus_addr;
          log_fc[log_n]   <= bus_fc;
          log_wr[log_n]   <= bus_write;
          log_wd[log_n]   <= bus_wdata;
        end
        log_n <= log_n + 1;
      end else begin
        wcnt <= wcnt - 1;
      end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic run_exc(logic [1:0] c, logic [7:0] v, logic [2:0] l, logic [15:0] s,
                         logic [31:0] pc, logic [31:0] sp, logic [31:0] vb,
                         logic [7:0] iv, bit poke);
    logic [31:0] e_addr [8];
    logic [2:0]  e_fc   [8];
    logic        e_wr   [8];
    logic [15:0] e_wd   [8];
    int          n;
    logic [7:0]  vn;
    logic [31:0] va;
    logic [15:0] esr;
    int          t;
    n   = 0;
    vn  = v;
    esr = exp_sr(c, s, l);
    if (c == 2'd1) begin
      e_addr[n] = iack_addr(l); e_fc[n] = 3'd7; e_wr[n] = 1'b0; e_wd[n] = '0; n++;
      vn = iv;
    end
    if (c != 2'd0) begin
      e_addr[n] = sp - 32'd2; e_fc[n] = 3'd5; e_wr[n] = 1'b1; e_wd[n] = pc[15:0];  n++;
      e_addr[n] = sp - 32'd4; e_fc[n] = 3'd5; e_wr[n] = 1'b1; e_wd[n] = pc[31:16]; n++;
      e_addr[n] = sp - 32'd6; e_fc[n] = 3'd5; e_wr[n] = 1'b1; e_wd[n] = s;         n++;
    end
    va = ((c == 2'd0) ? 32'd0 : vb) + {22'd0, vn, 2'b00};
    e_addr[n] = va;         e_fc[n] = (c == 2'd0) ? 3'd6 : 3'd5; e_wr[n] = 1'b0; e_wd[n] = '0; n++;
    e_addr[n] = va + 32'd2; e_fc[n] = (c == 2'd0) ? 3'd6 : 3'd5; e_wr[n] = 1'b0; e_wd[n] = '0; n++;

    @(negedge clk);
    log_n = 0; iack_vec = iv;
    req_cause = c; req_vector = v; req_level = l; sr_in = s;
    pc_in = pc; ssp_in = sp; vbr_in = vb; req_valid = 1'b1;
    chk("R1", "ready idle", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2", "sr update", {16'd0, sr_out}, {16'd0, esr});
    chk("R1", "ready busy", {31'd0, req_ready}, 32'd0);
    if (poke) begin
      req_cause = 2'd0; req_vector = ~v; req_level = ~l; sr_in = ~s;
      ssp_in = ~sp; vbr_in = ~vb; pc_in = ~pc; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    t = 0;
    while (!done && t < 300) begin
      @(negedge clk);
      t++;
    end
    chk("R7", "done seen", {31'd0, done}, 32'd1);
    chk("R7", "pc", pc_out, {mem_word(e_addr[n-2]), mem_word(e_addr[n-1])});
    chk(c == 2'd0 ? "R5" : "R4", "ssp", ssp_out, (c == 2'd0) ? sp : sp - 32'd6);
    chk("R1", "sr kept", {16'd0, sr_out}, {16'd0, esr});
    chk("R8", "access count", log_n, n);
    for (int i = 0; i < n && i < log_n; i++) begin
      string rq;
      if (c == 2'd1 && i == 0) rq = "R3";
      else if (e_wr[i]) rq = "R4";
      else if (c == 2'd0) rq = "R5";
      else rq = "R6";
      chk(rq, "addr", log_addr[i], e_addr[i]);
      chk(rq, "fc", {29'd0, log_fc[i]}, {29'd0, e_fc[i]});
      chk(rq, "dir", {31'd0, log_wr[i]}, {31'd0, e_wr[i]});
      if (e_wr[i]) chk(rq, "wdata", {16'd0, log_wd[i]}, {16'd0, e_wd[i]});
    end
    @(negedge clk);
    chk("R7", "done single", {31'd0, done}, 32'd0);
    chk("R1", "ready after", {31'd0, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog act=%0d exp=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "sr", {16'd0, sr_out}, 32'h2700);
    chk("R9", "pc", pc_out, 32'd0);
    chk("R9", "ssp", ssp_out, 32'd0);
    chk("R9", "done", {31'd0, done}, 32'd0);
    chk("R9", "bus_valid", {31'd0, bus_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "ready", {31'd0, req_ready}, 32'd1);

    // directed corners
    run_exc(2'd0, 8'h00, 3'd2, 16'hC315, 32'h1234_5678, 32'h0000_4000, 32'hDEAD_0000, 8'h00, 1'b0);
    run_exc(2'd1, 8'h11, 3'd7, 16'hFFFF, 32'hCAFE_BABE, 32'h0010_0000, 32'h8000_0000, 8'hFF, 1'b1);
    run_exc(2'd2, 8'h00, 3'd5, 16'h0000, 32'h0000_0002, 32'h0000_0004, 32'hFFFF_FFF0, 8'h00, 1'b0);
    run_exc(2'd3, 8'hFF, 3'd1, 16'h8704, 32'hFFFF_FFFE, 32'h0000_0000, 32'h0000_1000, 8'h00, 1'b1);
    run_exc(2'd1, 8'h00, 3'd1, 16'h4000, 32'h0040_0100, 32'h00FF_FFFE, 32'h0000_0000, 8'h40, 1'b0);
    run_exc(2'd0, 8'hAA, 3'd0, 16'h0000, 32'h0, 32'h0000_0010, 32'h0000_0400, 8'h00, 1'b1);

    // random mix
    for (int k = 0; k < 40; k++) begin
      run_exc(2'($urandom), 8'($urandom), 3'($urandom), 16'($urandom),
              $urandom, {$urandom} & 32'hFFFF_FFFE, $urandom & 32'hFFFF_FFFC,
              8'($urandom), ($urandom % 2) == 1);
    end

    chk("R8", "held while stalled", hold_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule